// File: doc/BRIEF.md
# Branch Direction Predictor

This block guesses whether a branch will be taken. Each cycle the fetch side can present a lookup made up of a branch identifier and a two-bit branch kind. The block answers taken or not taken in that same cycle, from combinational logic alone. Later, when the branch resolves, the execute side presents the same identifier, its kind and the real outcome. The block uses that to train a small direct-mapped table whose index is the low bits of the identifier.

A two-bit mode input picks the strategy that drives the answer. The choices are a fixed rule keyed on branch kind, a majority vote over the three most recent outcomes of the entry, and a four-state saturating counter per entry. Both trained tables learn from every resolve, whatever the mode, so switching mode at run time takes effect at once and needs no warm-up. Two counters, one for lookups and one for correct predictions, let the surrounding model measure accuracy.

Top module: `branch_dir_predictor`

## Requirements
- R1: With mode 00 (fixed rule), kinds 01 (unconditional), 10 (loop) and 11 (call/return) are predicted taken.
- R2: With mode 00, kind 00 (conditional) is predicted not taken.
- R3: With mode 01 (history), each resolve shifts its outcome into the entry's 3-bit history at the LSB. The prediction is taken when at least two of those three bits are 1.
- R4: With mode 10 (counter), states 00 and 01 predict not taken and states 10 and 11 predict taken. A taken outcome steps the state up and a not-taken outcome steps it down. The state saturates at 00 and 11.
- R5: After reset every history reads 000, every counter reads 01 and both statistics counters read 0.
- R6: Mode 11 behaves as mode 00. Both trained tables update on every resolve, whichever mode is selected.
- R7: The table entry is chosen by the low IDX_W bits of the identifier. Identifiers that differ only above those bits share an entry.
- R8: The prediction is valid in the same cycle as the lookup. A lookup and a resolve to the same entry in the same cycle give a prediction from the state before the resolve.
- R9: lookup_count rises by one after every cycle with lk_valid high, and holds otherwise.
- R10: correct_count rises by one after a resolve whose outcome equals the prediction the block would give, at that moment, for that entry and up_kind under the current mode, taken from the state before the resolve. Otherwise it holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Strategy select: 00 fixed, 01 history, 10 counter, 11 fixed |
| lk_valid | input | 1 | Lookup present this cycle (counted) |
| lk_id | input | ID_W | Identifier of the branch being looked up |
| lk_kind | input | 2 | Kind of the branch being looked up |
| lk_taken | output | 1 | Predicted direction for the lookup |
| up_valid | input | 1 | Resolve present this cycle |
| up_id | input | ID_W | Identifier of the resolved branch |
| up_kind | input | 2 | Kind of the resolved branch |
| up_taken | input | 1 | Actual outcome of the resolved branch |
| lookup_count | output | CNT_W | Number of lookups since reset |
| correct_count | output | CNT_W | Number of resolves whose outcome matched the prediction |

## Verification
The bench drives a counter up past 11 and then down past 00. A design that wraps instead of saturating would flip its prediction and produce a wrong answer a few steps later. In history mode it feeds alternating outcome sequences, so a vote taken over the wrong bits, or a shift in the wrong direction, would disagree with the expected majority. It also drives a lookup and a resolve to the same entry in the same cycle, which catches a design that forwards the new state early. Other tests check that aliasing identifiers share an entry, that mode 11 falls back to the fixed rule, and that training continues while another mode is active. A design that gated table writes by mode would give a stale prediction after a mode switch.

// File: rtl/bdp_pkg.sv
package bdp_pkg;

    typedef enum logic [1:0] {
        BK_COND    = 2'b00,
        BK_JUMP    = 2'b01,
        BK_LOOP    = 2'b10,
        BK_CALLRET = 2'b11
    } br_kind_e;

    typedef enum logic [1:0] {
        PM_FIXED   = 2'b00,
        PM_HISTORY = 2'b01,
        PM_COUNTER = 2'b10,
        PM_ALIAS   = 2'b11
    } pred_mode_e;

    localparam int HIST_LEN = 3;
    typedef logic [HIST_LEN-1:0] hist_t;
    typedef logic [1:0] sat_t;

    localparam hist_t HIST_INIT = '0;
    localparam sat_t  SAT_INIT  = 2'b01;
    localparam sat_t  SAT_MAX   = 2'b11;
    localparam sat_t  SAT_MIN   = 2'b00;

    // Candidate answers from the three strategies for one entry.
    typedef struct packed {
        logic fixed;
        logic hist;
        logic ctr;
    } vote_t;

    function automatic logic fixed_guess(br_kind_e kind);
        return (kind != BK_COND);
    endfunction

    function automatic logic hist_majority(hist_t h);
        return (($countones(h) * 2) > HIST_LEN);
    endfunction

    function automatic logic sat_says(sat_t s);
        return s[1];
    endfunction

    function automatic sat_t sat_step(sat_t s, logic taken);
        sat_t n;
        n = s;
        if (taken && s != SAT_MAX) begin
            n = s + 2'd1;
        end else if (!taken && s != SAT_MIN) begin
            n = s - 2'd1;
        end
        return n;
    endfunction

    function automatic logic pick(pred_mode_e m, vote_t v);
        logic r;
        case (m)
            PM_HISTORY: r = v.hist;
            PM_COUNTER: r = v.ctr;
            default:    r = v.fixed;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/bdp_hist_table.sv
module bdp_hist_table
    import bdp_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken,
    input  logic [IDX_W-1:0] rd_a_idx,
    input  logic [IDX_W-1:0] rd_b_idx,
    output hist_t            rd_a,
    output hist_t            rd_b
);
    localparam int ENTRIES = 1 << IDX_W;

    hist_t hist_q [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                hist_q[e] <= HIST_INIT;
            end else if (wr_en && wr_idx == IDX_W'(e)) begin
                hist_q[e] <= {hist_q[e][HIST_LEN-2:0], wr_taken};
            end
        end
    end

    assign rd_a = hist_q[rd_a_idx];
    assign rd_b = hist_q[rd_b_idx];
endmodule

// File: rtl/bdp_ctr_table.sv
module bdp_ctr_table
    import bdp_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken,
    input  logic [IDX_W-1:0] rd_a_idx,
    input  logic [IDX_W-1:0] rd_b_idx,
    output sat_t             rd_a,
    output sat_t             rd_b
);
    localparam int ENTRIES = 1 << IDX_W;

    sat_t ctr_q [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                ctr_q[e] <= SAT_INIT;
            end else if (wr_en && wr_idx == IDX_W'(e)) begin
                ctr_q[e] <= sat_step(ctr_q[e], wr_taken);
            end
        end
    end

    assign rd_a = ctr_q[rd_a_idx];
    assign rd_b = ctr_q[rd_b_idx];
endmodule

// File: rtl/bdp_stats.sv
module bdp_stats #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lk_fire,
    input  logic             up_fire,
    input  logic             up_hit,
    output logic [CNT_W-1:0] lk_cnt,
    output logic [CNT_W-1:0] ok_cnt
);
    always_ff @(posedge clk) begin
        if (rst) begin
            lk_cnt <= '0;
            ok_cnt <= '0;
        end else begin
            if (lk_fire) begin
                lk_cnt <= lk_cnt + CNT_W'(1);
            end
            if (up_fire && up_hit) begin
                ok_cnt <= ok_cnt + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/branch_dir_predictor.sv
module branch_dir_predictor
    import bdp_pkg::*;
#(
    parameter int ID_W  = 8,
    parameter int IDX_W = 4,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode,
    input  logic             lk_valid,
    input  logic [ID_W-1:0]  lk_id,
    input  logic [1:0]       lk_kind,
    output logic             lk_taken,
    input  logic             up_valid,
    input  logic [ID_W-1:0]  up_id,
    input  logic [1:0]       up_kind,
    input  logic             up_taken,
    output logic [CNT_W-1:0] lookup_count,
    output logic [CNT_W-1:0] correct_count
);
    logic [IDX_W-1:0] lk_idx;
    logic [IDX_W-1:0] up_idx;
    hist_t            lk_h;
    hist_t            up_h;
    sat_t             lk_c;
    sat_t             up_c;
    vote_t            lk_v;
    vote_t            up_v;
    pred_mode_e       mode_e;
    logic             up_hit;

    assign lk_idx = lk_id[IDX_W-1:0];
    assign up_idx = up_id[IDX_W-1:0];
    assign mode_e = pred_mode_e'(mode);

    bdp_hist_table #(.IDX_W(IDX_W)) i_hist (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (up_valid),
        .wr_idx   (up_idx),
        .wr_taken (up_taken),
        .rd_a_idx (lk_idx),
        .rd_b_idx (up_idx),
        .rd_a     (lk_h),
        .rd_b     (up_h)
    );

    bdp_ctr_table #(.IDX_W(IDX_W)) i_ctr (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (up_valid),
        .wr_idx   (up_idx),
        .wr_taken (up_taken),
        .rd_a_idx (lk_idx),
        .rd_b_idx (up_idx),
        .rd_a     (lk_c),
        .rd_b     (up_c)
    );

    always_comb begin
        lk_v.fixed = fixed_guess(br_kind_e'(lk_kind));
        lk_v.hist  = hist_majority(lk_h);
        lk_v.ctr   = sat_says(lk_c);
        up_v.fixed = fixed_guess(br_kind_e'(up_kind));
        up_v.hist  = hist_majority(up_h);
        up_v.ctr   = sat_says(up_c);
    end

    assign lk_taken = pick(mode_e, lk_v);
    assign up_hit   = (pick(mode_e, up_v) == up_taken);

    bdp_stats #(.CNT_W(CNT_W)) i_stats (
        .clk     (clk),
        .rst     (rst),
        .lk_fire (lk_valid),
        .up_fire (up_valid),
        .up_hit  (up_hit),
        .lk_cnt  (lookup_count),
        .ok_cnt  (correct_count)
    );
endmodule

// File: rtl/bdp_checker.sv
module bdp_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       mode,
    input logic             lk_valid,
    input logic [1:0]       lk_kind,
    input logic             lk_taken,
    input logic             up_valid,
    input logic [CNT_W-1:0] lookup_count,
    input logic [CNT_W-1:0] correct_count
);
    // R1
    fixed_taken_chk: assert property (@(posedge clk) disable iff (rst)
        ((mode == 2'b00 || mode == 2'b11) && lk_kind != 2'b00) |-> lk_taken);

    // R2
    fixed_cond_chk: assert property (@(posedge clk) disable iff (rst)
        ((mode == 2'b00 || mode == 2'b11) && lk_kind == 2'b00) |-> !lk_taken);

    // R9
    lookup_step_chk: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> lookup_count == $past(lookup_count) + CNT_W'(1));

    // R9
    lookup_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> $stable(lookup_count));

    // R10
    correct_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !up_valid |=> $stable(correct_count));

    // R10
    correct_step_chk: assert property (@(posedge clk) disable iff (rst)
        up_valid |=> (correct_count - $past(correct_count)) <= CNT_W'(1));
endmodule

bind branch_dir_predictor bdp_checker #(.CNT_W(CNT_W)) i_bdp_checker (
    .clk           (clk),
    .rst           (rst),
    .mode          (mode),
    .lk_valid      (lk_valid),
    .lk_kind       (lk_kind),
    .lk_taken      (lk_taken),
    .up_valid      (up_valid),
    .lookup_count  (lookup_count),
    .correct_count (correct_count)
);

// File: tb/test_branch_dir_predictor.sv
module test_branch_dir_predictor;
    localparam int ID_W  = 8;
    localparam int IDX_W = 4;
    localparam int CNT_W = 32;
    localparam int NENT  = 1 << IDX_W;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [1:0]       mode = 2'b00;
    logic             lk_valid = 1'b0;
    logic [ID_W-1:0]  lk_id = '0;
    logic [1:0]       lk_kind = '0;
    logic             lk_taken;
    logic             up_valid = 1'b0;
    logic [ID_W-1:0]  up_id = '0;
    logic [1:0]       up_kind = '0;
    logic             up_taken = 1'b0;
    logic [CNT_W-1:0] lookup_count;
    logic [CNT_W-1:0] correct_count;

    int total = 0;
    int bad   = 0;
    int exp_lk = 0;
    int exp_ok = 0;
    logic [2:0] mh [NENT];
    logic [1:0] mc [NENT];

    always #4 clk = ~clk;

    branch_dir_predictor #(.ID_W(ID_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) i_branch_dir_predictor (
        .clk(clk), .rst(rst), .mode(mode),
        .lk_valid(lk_valid), .lk_id(lk_id), .lk_kind(lk_kind), .lk_taken(lk_taken),
        .up_valid(up_valid), .up_id(up_id), .up_kind(up_kind), .up_taken(up_taken),
        .lookup_count(lookup_count), .correct_count(correct_count)
    );

    // Expected prediction computed from the requirements.
    function automatic logic mpred(logic [1:0] md, logic [1:0] kind, int e);
        int ones;
        ones = int'(mh[e][0]) + int'(mh[e][1]) + int'(mh[e][2]);
        if (md == 2'b01) return (ones >= 2);
        if (md == 2'b10) return mc[e][1];
        return (kind != 2'b00);
    endfunction

    task automatic check(input logic [31:0] got, input logic [31:0] want, input string req);
        total++;
        if (got !== want) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, want);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        lk_valid = 1'b0;
        up_valid = 1'b0;
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk);
        lk_valid = 1'b0;
        up_valid = 1'b0;
        mode = m;
    endtask

    // One cycle with an optional lookup and an optional resolve.
    task automatic cyc(input logic lv, input logic [ID_W-1:0] lid, input logic [1:0] lkd,
                       input logic uv, input logic [ID_W-1:0] uid, input logic [1:0] ukd,
                       input logic ut, output logic got);
        int ue;
        @(negedge clk);
        lk_valid = lv; lk_id = lid; lk_kind = lkd;
        up_valid = uv; up_id = uid; up_kind = ukd; up_taken = ut;
        ue = int'(uid) % NENT;
        if (lv) exp_lk++;
        if (uv && mpred(mode, ukd, ue) == ut) exp_ok++;
        #1 got = lk_taken;
        @(posedge clk);
        if (uv) begin
            mh[ue] = {mh[ue][1:0], ut};
            if (ut && mc[ue] != 2'b11) mc[ue] = mc[ue] + 2'd1;
            else if (!ut && mc[ue] != 2'b00) mc[ue] = mc[ue] - 2'd1;
        end
    endtask

    task automatic look(input logic [ID_W-1:0] id, input logic [1:0] kd, input logic want, input string req);
        logic g;
        cyc(1'b1, id, kd, 1'b0, '0, '0, 1'b0, g);
        check(32'(g), 32'(want), req);
    endtask

    task automatic upd(input logic [ID_W-1:0] id, input logic t);
        logic g;
        cyc(1'b0, '0, '0, 1'b1, id, 2'b00, t, g);
    endtask

    task automatic t_reset();
        idle();
        check(lookup_count, 0, "R5 lookup_count");
        check(correct_count, 0, "R5 correct_count");
        set_mode(2'b01);
        look(8'd7, 2'b01, 1'b0, "R5 history clear");
        set_mode(2'b10);
        look(8'd7, 2'b01, 1'b0, "R5 counter at 01");
    endtask

    task automatic t_fixed();
        set_mode(2'b00);
        look(8'd2, 2'b00, 1'b0, "R2 conditional");
        look(8'd2, 2'b01, 1'b1, "R1 unconditional");
        look(8'd2, 2'b10, 1'b1, "R1 loop");
        look(8'd2, 2'b11, 1'b1, "R1 call/return");
        set_mode(2'b11);
        look(8'd2, 2'b01, 1'b1, "R6 mode 11 as fixed taken");
        look(8'd2, 2'b00, 1'b0, "R6 mode 11 as fixed not taken");
    endtask

    task automatic t_history();
        set_mode(2'b01);
        upd(8'd3, 1'b1); upd(8'd3, 1'b0); upd(8'd3, 1'b1);
        look(8'd3, 2'b00, 1'b1, "R3 after T,N,T");
        upd(8'd3, 1'b0);
        look(8'd3, 2'b00, 1'b0, "R3 after T,N,T,N");
        upd(8'd3, 1'b1);
        look(8'd3, 2'b01, 1'b1, "R3 after ...N,T");
        upd(8'd3, 1'b0); upd(8'd3, 1'b0);
        look(8'd3, 2'b01, 1'b0, "R3 after ...T,N,N");
        upd(8'd3, 1'b1); upd(8'd3, 1'b1);
        look(8'd3, 2'b00, 1'b1, "R3 after ...N,T,T");
        // Counter for entry 3 trained meanwhile: ends at 10.
        set_mode(2'b10);
        look(8'd3, 2'b00, 1'b1, "R6 counter trained in history mode");
    endtask

    task automatic t_counter();
        set_mode(2'b10);
        upd(8'd9, 1'b1); upd(8'd9, 1'b1); upd(8'd9, 1'b1); upd(8'd9, 1'b1);
        look(8'd9, 2'b00, 1'b1, "R4 saturated high");
        upd(8'd9, 1'b0);
        look(8'd9, 2'b00, 1'b1, "R4 11 down to 10");
        upd(8'd9, 1'b0);
        look(8'd9, 2'b00, 1'b0, "R4 10 down to 01");
        upd(8'd9, 1'b0); upd(8'd9, 1'b0); upd(8'd9, 1'b1);
        look(8'd9, 2'b00, 1'b0, "R4 saturated low then 01");
        upd(8'd9, 1'b1);
        look(8'd9, 2'b00, 1'b1, "R4 01 up to 10");
        // History for entry 9 trained meanwhile: last three N,T,T.
        set_mode(2'b01);
        look(8'd9, 2'b00, 1'b1, "R6 history trained in counter mode");
    endtask

    task automatic t_same_cycle();
        logic g;
        set_mode(2'b10);
        cyc(1'b1, 8'd12, 2'b00, 1'b1, 8'd12, 2'b00, 1'b1, g);
        check(32'(g), 0, "R8 lookup sees pre-update state");
        look(8'd12, 2'b00, 1'b1, "R8 update visible next cycle");
    endtask

    task automatic t_alias();
        set_mode(2'b10);
        upd(8'h25, 1'b1);
        look(8'h05, 2'b00, 1'b1, "R7 alias shares entry");
        look(8'h06, 2'b00, 1'b0, "R7 neighbour untouched");
    endtask

    task automatic t_stats();
        int ok0;
        idle();
        check(lookup_count, 32'(exp_lk), "R9 lookup_count");
        check(correct_count, 32'(exp_ok), "R10 correct_count");
        ok0 = exp_ok;
        set_mode(2'b00);
        upd(8'd1, 1'b0);
        idle();
        check(correct_count, 32'(ok0 + 1), "R10 correct fixed guess counted");
        upd(8'd1, 1'b1);
        idle();
        check(correct_count, 32'(ok0 + 1), "R10 wrong fixed guess not counted");
        check(lookup_count, 32'(exp_lk), "R9 lookup_count unchanged by resolves");
    endtask

    initial begin
        #(8 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int e = 0; e < NENT; e++) begin
            mh[e] = 3'b000;
            mc[e] = 2'b01;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_fixed();
        t_history();
        t_counter();
        t_same_cycle();
        t_alias();
        t_stats();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule